// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit holds the status, interrupt-enable, FIFO-control and control registers that sit beside an SPI shift engine. It compares the live transmit and receive FIFO word counts against two programmable watermarks and raises level request flags from them. It also latches single-cycle frame-done and transfer-done pulses from the engine into sticky flags that software clears by writing ones. It mirrors the engine's busy line into the status word. A single level interrupt is raised whenever any status flag is set whose enable bit is also set.

Software reaches the unit through a plain word-addressed write/read port. Register select (3 bits): 0 control, 1 status, 2 interrupt enable, 3 FIFO control, 4 FIFO status, 5 parameters; other codes read zero. Read data is registered: it shows the selected register one clock after the select is applied. The FIFO storage and the shift engine stay outside the unit. The unit only supplies their watermarks, enable and flush pulses.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset the enable, interrupt-enable, watermark and sticky flags are all zero, `irq`, `mod_en`, `tx_flush` and `rx_flush` are low, and the status word holds only the live flags.
- R2: Status bit 0 (transmit request) is 1 exactly while `tx_count` is less than or equal to the transmit watermark; writing a 1 to it has no effect.
- R3: Status bit 1 (receive ready) is 1 exactly while `rx_count` is greater than the receive watermark; writing a 1 to it has no effect.
- R4: Status bit 9 (frame complete) is set by a `frame_done` pulse. It stays set until a status write has bit 9 at 1. Writing 0 to bit 9, or writing 1 to other bits, leaves it set.
- R5: Status bit 10 (transfer complete) is set by an `xfer_done` pulse and is cleared only by a status write with bit 10 at 1.
- R6: If a set pulse and a clearing write reach the same sticky flag in the same cycle, the flag ends the cycle set.
- R7: Status bit 24 (busy) follows `engine_busy`.
- R8: The interrupt-enable register keeps only bits 0, 1, 9 and 10. `irq` goes high one clock after the AND of status and interrupt-enable becomes non-zero, and goes low one clock after that AND becomes zero.
- R9: The FIFO control register holds the transmit watermark in bits [TX_LOG2-1:0] and the receive watermark in bits [16+RX_LOG2-1:16]. Other bits read zero.
- R10: The FIFO status register returns `tx_count` in bits 7:0 and `rx_count` in bits 23:16.
- R11: The parameter register returns TX_LOG2 in bits 3:0 and RX_LOG2 in bits 11:8.
- R12: Control bit 0 is the stored module enable, driven on `mod_en`. Writing 1 to control bit 8 or bit 9 gives a one-clock pulse on `tx_flush` or `rx_flush`, one clock after the write. Bits 8 and 9 read back as 0.
- R13: A control write with bit 1 at 1 returns the enable, interrupt-enable, watermarks and sticky flags to zero in that same clock edge; bit 1 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| tx_count | input | TX_LOG2+1 | Transmit FIFO word count |
| rx_count | input | RX_LOG2+1 | Receive FIFO word count |
| frame_done | input | 1 | One-cycle pulse at the end of a frame |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| engine_busy | input | 1 | Shift engine busy level |
| mod_en | output | 1 | Module enable |
| tx_flush | output | 1 | One-cycle transmit FIFO flush pulse |
| rx_flush | output | 1 | One-cycle receive FIFO flush pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The case that matters most is a `frame_done` pulse arriving in the same cycle that software writes 1 to clear bit 9. The bench first sets the flag with an earlier pulse. It then raises the pulse and the clearing write on the same falling edge, so both are seen by one rising edge. The status read-back must still show bit 9 at 1, and a later lone clearing write must show it at 0. The interrupt is checked the same way across enable and flag changes. This confirms that it rises and falls one clock after its cause.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_IEN   = 3'd2,
    A_FCTL  = 3'd3,
    A_FSTAT = 3'd4,
    A_PARAM = 3'd5
  } reg_sel_e;

  // status / enable bit positions
  localparam int B_TDR   = 0;
  localparam int B_RDR   = 1;
  localparam int B_FRM   = 9;
  localparam int B_XFR   = 10;
  localparam int B_BUSY  = 24;
  localparam int EVT_LO  = 8;
  localparam int EVT_HI  = 13;
  localparam int N_EVT   = EVT_HI - EVT_LO + 1;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_SRST  = 1;
  localparam int B_TXFL  = 8;
  localparam int B_RXFL  = 9;

  localparam int RXWM_LSB   = 16;
  localparam int RXCNT_LSB  = 16;
  localparam int RXLOG_LSB  = 8;

  localparam logic [31:0] IEN_MASK = 32'h0000_0603;

endpackage

// File: rtl/spi_stat_cfg.sv
module spi_stat_cfg
  import spi_stat_pkg::*;
#(
  parameter int TXW = 4,
  parameter int RXW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              mod_en,
  output logic [31:0]       ien,
  output logic [TXW-1:0]    tx_wm,
  output logic [RXW-1:0]    rx_wm,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              soft_clr
);

  logic ctrl_wr, ien_wr, fctl_wr;

  assign ctrl_wr  = wr && (addr == A_CTRL);
  assign ien_wr   = wr && (addr == A_IEN);
  assign fctl_wr  = wr && (addr == A_FCTL);
  assign soft_clr = ctrl_wr && wdata[B_SRST];

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      mod_en <= 1'b0;
      ien    <= '0;
      tx_wm  <= '0;
      rx_wm  <= '0;
    end else begin
      if (ctrl_wr) mod_en <= wdata[B_EN];
      if (ien_wr)  ien    <= wdata & IEN_MASK;
      if (fctl_wr) begin
        tx_wm <= wdata[TXW-1:0];
        rx_wm <= wdata[RXWM_LSB +: RXW];
      end
    end
  end

  // flush strobes are self-clearing single-cycle pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flush <= 1'b0;
      rx_flush <= 1'b0;
    end else begin
      tx_flush <= ctrl_wr && wdata[B_TXFL];
      rx_flush <= ctrl_wr && wdata[B_RXFL];
    end
  end

  AST_TXFL_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_flush) |-> $past(ctrl_wr && wdata[B_TXFL])); // R12
  AST_RXFL_ONE: assert property (@(posedge clk) disable iff (rst)
    (rx_flush && !$past(ctrl_wr && wdata[B_RXFL])) |-> 1'b0 ); // R12
  AST_SRST_CLR: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (!mod_en && ien == '0 && tx_wm == '0 && rx_wm == '0)); // R13

endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
#(
  parameter int TX_CW = 5,
  parameter int RX_CW = 5,
  parameter int TXW   = 4,
  parameter int RXW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TX_CW-1:0] tx_count,
  input  logic [RX_CW-1:0] rx_count,
  input  logic [TXW-1:0]   tx_wm,
  input  logic [RXW-1:0]   rx_wm,
  input  logic             frame_evt,
  input  logic             xfer_evt,
  input  logic             busy,
  input  logic             w1c,
  input  logic [N_EVT-1:0] w1c_bits,
  input  logic             soft_clr,
  output logic [31:0]      status
);

  logic [N_EVT-1:0] evt_in, evt_q;
  logic             tdr, rdr;

  always_comb begin
    evt_in = '0;
    evt_in[B_FRM-EVT_LO] = frame_evt;
    evt_in[B_XFR-EVT_LO] = xfer_evt;
  end

  // sticky flags: a set pulse wins over a same-cycle clearing write
  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      evt_q <= '0;
    end else begin
      for (int i = 0; i < N_EVT; i++) begin
        if (evt_in[i])                   evt_q[i] <= 1'b1;
        else if (w1c && w1c_bits[i])     evt_q[i] <= 1'b0;
      end
    end
  end

  assign tdr = (tx_count <= TX_CW'(tx_wm));
  assign rdr = (rx_count >  RX_CW'(rx_wm));

  always_comb begin
    status                 = '0;
    status[B_TDR]          = tdr;
    status[B_RDR]          = rdr;
    status[EVT_HI:EVT_LO]  = evt_q;
    status[B_BUSY]         = busy;
  end

  AST_FRM_SET: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && !soft_clr) |=> status[B_FRM]); // R6
  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status[B_FRM] && !(w1c && w1c_bits[B_FRM-EVT_LO]) && !soft_clr) |=> status[B_FRM]); // R4
  AST_XFR_SET: assert property (@(posedge clk) disable iff (rst)
    (xfer_evt && !soft_clr) |=> status[B_XFR]); // R5
  AST_XFR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status[B_XFR] && !(w1c && w1c_bits[B_XFR-EVT_LO]) && !soft_clr) |=> status[B_XFR]); // R5

endmodule

// File: rtl/spi_stat_rdbk.sv
module spi_stat_rdbk
  import spi_stat_pkg::*;
#(
  parameter int TX_LOG2 = 4,
  parameter int RX_LOG2 = 4,
  parameter int TX_CW   = TX_LOG2 + 1,
  parameter int RX_CW   = RX_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               mod_en,
  input  logic [31:0]        ien,
  input  logic [TX_LOG2-1:0] tx_wm,
  input  logic [RX_LOG2-1:0] rx_wm,
  input  logic [31:0]        status,
  input  logic [TX_CW-1:0]   tx_count,
  input  logic [RX_CW-1:0]   rx_count,
  output logic [31:0]        rdata,
  output logic               irq
);

  logic [31:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    case (addr)
      A_CTRL:  rd_nxt[B_EN] = mod_en;
      A_STAT:  rd_nxt = status;
      A_IEN:   rd_nxt = ien;
      A_FCTL: begin
        rd_nxt[TX_LOG2-1:0]         = tx_wm;
        rd_nxt[RXWM_LSB +: RX_LOG2] = rx_wm;
      end
      A_FSTAT: begin
        rd_nxt[TX_CW-1:0]           = tx_count;
        rd_nxt[RXCNT_LSB +: RX_CW]  = rx_count;
      end
      A_PARAM: begin
        rd_nxt[3:0]                 = 4'(TX_LOG2);
        rd_nxt[RXLOG_LSB +: 4]      = 4'(RX_LOG2);
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_nxt;
      irq   <= |(status & ien);
    end
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq); // R8

endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
  import spi_stat_pkg::*;
#(
  parameter int TX_LOG2 = 4,
  parameter int RX_LOG2 = 4,
  localparam int TX_CW  = TX_LOG2 + 1,
  localparam int RX_CW  = RX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [TX_CW-1:0]  tx_count,
  input  logic [RX_CW-1:0]  rx_count,
  input  logic              frame_done,
  input  logic              xfer_done,
  input  logic              engine_busy,
  output logic              mod_en,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              irq
);

  logic [31:0]        ien;
  logic [31:0]        status;
  logic [TX_LOG2-1:0] tx_wm;
  logic [RX_LOG2-1:0] rx_wm;
  logic               soft_clr;
  logic               stat_wr;

  assign stat_wr = reg_wr && (reg_addr == A_STAT);

  spi_stat_cfg #(.TXW(TX_LOG2), .RXW(RX_LOG2)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mod_en(mod_en), .ien(ien), .tx_wm(tx_wm), .rx_wm(rx_wm),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .soft_clr(soft_clr)
  );

  spi_stat_flags #(.TX_CW(TX_CW), .RX_CW(RX_CW), .TXW(TX_LOG2), .RXW(RX_LOG2)) u_flags (
    .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
    .tx_wm(tx_wm), .rx_wm(rx_wm), .frame_evt(frame_done), .xfer_evt(xfer_done),
    .busy(engine_busy), .w1c(stat_wr), .w1c_bits(reg_wdata[EVT_HI:EVT_LO]),
    .soft_clr(soft_clr), .status(status)
  );

  spi_stat_rdbk #(.TX_LOG2(TX_LOG2), .RX_LOG2(RX_LOG2), .TX_CW(TX_CW), .RX_CW(RX_CW)) u_rdbk (
    .clk(clk), .rst(rst), .addr(reg_addr), .mod_en(mod_en), .ien(ien),
    .tx_wm(tx_wm), .rx_wm(rx_wm), .status(status), .tx_count(tx_count),
    .rx_count(rx_count), .rdata(reg_rdata), .irq(irq)
  );

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (frame_done && ien[B_FRM] && !soft_clr && !(reg_wr && reg_addr == A_IEN)) |=> ##1 irq); // R8
  AST_BUSY_SEEN: assert property (@(posedge clk) disable iff (rst)
    (engine_busy && reg_addr == A_STAT) |=> reg_rdata[B_BUSY]); // R7

endmodule

// File: tb/spi_stat_irq_tb_top.sv
module spi_stat_irq_tb_top;

  localparam int TXL = 4;
  localparam int RXL = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [TXL:0] tx_count = '0;
  logic [RXL:0] rx_count = '0;
  logic        frame_done = 1'b0;
  logic        xfer_done = 1'b0;
  logic        engine_busy = 1'b0;
  logic        mod_en, tx_flush, rx_flush, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit pend = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  spi_stat_irq #(.TX_LOG2(TXL), .RX_LOG2(RXL)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_count(tx_count),
    .rx_count(rx_count), .frame_done(frame_done), .xfer_done(xfer_done),
    .engine_busy(engine_busy), .mod_en(mod_en), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .irq(irq)
  );

  // monitor: pops the expected item and compares once the result is registered
  initial begin
    forever begin
      @(posedge clk);
      if (pend) begin
        logic [32:0] it;
        logic [31:0] act;
        string       t;
        #2;
        it  = exp_q.pop_front();
        t   = tag_q.pop_front();
        act = it[32] ? {31'b0, irq} : reg_rdata;
        n_chk++;
        if (act !== it[31:0]) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, act, it[31:0]);
        end
      end
    end
  end

  task automatic direct(input logic [31:0] act, input logic [31:0] e, input string t);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back({1'b0, e});
    tag_q.push_back(t);
    pend = 1'b1;
    @(negedge clk);
    pend = 1'b0;
  endtask

  task automatic exp_irq(input logic e, input string t);
    @(negedge clk);
    exp_q.push_back({1'b1, 31'b0, e});
    tag_q.push_back(t);
    pend = 1'b1;
    @(negedge clk);
    pend = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    direct({31'b0, irq}, 32'h0, "R1 irq after reset");
    direct({29'b0, mod_en, tx_flush, rx_flush}, 32'h0, "R1 outputs after reset");
    exp_rd(3'd1, 32'h0000_0001, "R1 status after reset");
    exp_rd(3'd2, 32'h0, "R1 ien after reset");
    exp_rd(3'd3, 32'h0, "R1 fifo ctrl after reset");
    exp_rd(3'd0, 32'h0, "R1 ctrl after reset");

    // R9 watermark fields
    wr(3'd3, 32'hFFFF_FFFF);
    exp_rd(3'd3, 32'h000F_000F, "R9 fifo ctrl field masking");
    wr(3'd3, 32'h0005_0003);
    exp_rd(3'd3, 32'h0005_0003, "R9 fifo ctrl readback");

    // R2 transmit level flag, boundary at watermark 3
    tx_count = 5'd3;
    exp_rd(3'd1, 32'h0000_0001, "R2 tx count equals watermark");
    tx_count = 5'd4;
    exp_rd(3'd1, 32'h0000_0000, "R2 tx count above watermark");
    tx_count = 5'd3;
    wr(3'd1, 32'h0000_0003);
    exp_rd(3'd1, 32'h0000_0001, "R2 write one does not clear");

    // R3 receive level flag, boundary at watermark 5
    tx_count = 5'd9;
    rx_count = 5'd5;
    exp_rd(3'd1, 32'h0000_0000, "R3 rx count equals watermark");
    rx_count = 5'd6;
    exp_rd(3'd1, 32'h0000_0002, "R3 rx count above watermark");
    wr(3'd1, 32'h0000_0002);
    exp_rd(3'd1, 32'h0000_0002, "R3 write one does not clear");

    // R10 fifo status, R11 parameters
    rx_count = 5'd16;
    exp_rd(3'd4, 32'h0010_0009, "R10 fifo counts");
    rx_count = 5'd0;
    exp_rd(3'd5, 32'h0000_0404, "R11 depth parameters");
    exp_rd(3'd6, 32'h0, "R11 unmapped select reads zero");

    // R4 frame complete sticky flag
    pulse_frame();
    exp_rd(3'd1, 32'h0000_0200, "R4 frame flag set");
    wr(3'd1, 32'h0000_0000);
    exp_rd(3'd1, 32'h0000_0200, "R4 write zero keeps flag");
    wr(3'd1, 32'h0000_0400);
    exp_rd(3'd1, 32'h0000_0200, "R4 other bit write keeps flag");
    wr(3'd1, 32'h0000_0200);
    exp_rd(3'd1, 32'h0000_0000, "R4 write one clears");

    // R5 transfer complete sticky flag
    pulse_xfer();
    exp_rd(3'd1, 32'h0000_0400, "R5 transfer flag set");
    wr(3'd1, 32'h0000_0400);
    exp_rd(3'd1, 32'h0000_0000, "R5 write one clears");

    // R6 set and clear in the same cycle
    pulse_frame();
    @(negedge clk);
    frame_done = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0000_0200;
    @(negedge clk);
    frame_done = 1'b0;
    reg_wr = 1'b0; reg_wdata = '0;
    exp_rd(3'd1, 32'h0000_0200, "R6 set wins over same-cycle clear");
    wr(3'd1, 32'h0000_0200);
    exp_rd(3'd1, 32'h0000_0000, "R6 later clear takes effect");

    // R7 busy mirror
    engine_busy = 1'b1;
    exp_rd(3'd1, 32'h0100_0000, "R7 busy shown");
    engine_busy = 1'b0;
    exp_rd(3'd1, 32'h0000_0000, "R7 busy gone");

    // R8 interrupt
    wr(3'd2, 32'hFFFF_FFFF);
    exp_rd(3'd2, 32'h0000_0603, "R8 enable mask");
    exp_irq(1'b0, "R8 no enabled flag");
    pulse_frame();
    exp_irq(1'b1, "R8 frame flag raises irq");
    wr(3'd1, 32'h0000_0200);
    exp_irq(1'b0, "R8 clear drops irq");
    engine_busy = 1'b1;
    idle(1);
    exp_irq(1'b0, "R8 busy is not an interrupt source");
    engine_busy = 1'b0;
    tx_count = 5'd0;
    idle(1);
    exp_irq(1'b1, "R8 transmit request raises irq");
    wr(3'd2, 32'h0);
    exp_irq(1'b0, "R8 disable drops irq");
    tx_count = 5'd9;

    // R12 control enable and flush pulses
    wr(3'd0, 32'h0000_0301);
    direct({30'b0, tx_flush, rx_flush}, 32'h3, "R12 flush pulses high");
    direct({31'b0, mod_en}, 32'h1, "R12 enable output");
    @(negedge clk);
    direct({30'b0, tx_flush, rx_flush}, 32'h0, "R12 flush pulses one cycle");
    exp_rd(3'd0, 32'h0000_0001, "R12 flush bits read zero");

    // R13 software reset
    wr(3'd2, 32'h0000_0603);
    wr(3'd3, 32'h0002_0001);
    pulse_xfer();
    wr(3'd0, 32'h0000_0003);
    direct({31'b0, mod_en}, 32'h0, "R13 enable cleared");
    exp_rd(3'd0, 32'h0, "R13 ctrl reads zero");
    exp_rd(3'd2, 32'h0, "R13 ien cleared");
    exp_rd(3'd3, 32'h0, "R13 watermarks cleared");
    exp_rd(3'd1, 32'h0, "R13 sticky flags cleared");
    exp_irq(1'b0, "R13 irq low");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule